// File: doc/BRIEF.md
# Two-Channel Instruction Breakpoint Unit

This block observes the bus cycles a processor issues and raises a break request when either of its two watch channels recognises a programmed condition. Each channel compares the cycle address against a stored value. An address mask marks bits as don't-care, so one channel can cover a whole aligned window or a set of scattered addresses. A channel can be restricted to instruction fetches or data accesses, to reads or writes, and optionally to one operand size.

Each channel is set either to break before the matched instruction executes or to break after it retires. In the second case the channel arms on the fetch and fires on the next retire strobe. Channel B adds a masked data compare and an execution counter, so that only the Nth qualifying occurrence breaks. The two channels work independently. Each channel has a sticky hit flag. Software programs the channels, and clears the flags, through a simple write port.

Register selects on the write port:
- 0, 1, 2: channel A address, address mask, condition.
- 3, 4, 5: channel B address, address mask, condition.
- 6, 7: channel B data, data mask.
- 8: flag clear.
- 9: channel B count.

Condition word bits:
- bit0: match fetches.
- bit1: match data accesses.
- bit2: match reads.
- bit3: match writes.
- bit4: size check enable.
- bits6:5: size code (0 byte, 1 word, 2 long).
- bit7: after-execution mode.
- bit8: count enable (channel B only).
- bit9: data compare enable (channel B only).

Top module: `brk_unit`

## Requirements
- R1: An address bit whose mask bit is 1 is ignored. With compare 0x00008404 and mask 0x00000FFF, fetches 0x8000 and 0x8FFE hit and 0x9000 misses. With compare 0x00008010 and mask 0x00000006, fetches 0x8010 to 0x8016 in steps of 2 hit, while 0x8011 and 0x8018 miss.
- R2: A cycle matches only if its type is enabled (condition bit0 for fetch, bit1 for data) and its direction is enabled (bit2 for read, bit3 for write).
- R3: With condition bit4 set, the access size must equal bits6:5. With bit4 clear, every size matches.
- R4: In before mode (bit7 = 0), breakReq pulses high, and the channel flag sets, in the clock cycle after the matching bus cycle.
- R5: In after mode (bit7 = 1), a match arms the channel. breakReq and the flag follow one cycle after the next retire strobe, and no break occurs while no retire arrives.
- R6: With channel B bit8 set and a count N loaded through select 9, the first N-1 qualifying events pass silently and the Nth breaks. The counter then holds at 1, so every later event breaks. A write to select 9 reloads the count.
- R7: With channel B bit9 set, bits where the data mask is 0 must equal the data register. Data 0 with data mask 0 is a valid condition that matches only zero data.
- R8: The channels break independently. When both fire in one cycle, both flags set and a single one-cycle breakReq pulse is issued.
- R9: Flags are sticky. A write to select 8 clears flag A where bit0 is 0 and flag B where bit1 is 0. A channel firing in the same cycle as the clear keeps its flag set.
- R10: After reset all registers, flags and breakReq are 0, and no bus cycle matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgSel | input | 4 | Register select |
| cfgWrData | input | WORD_W | Register write data |
| busValid | input | 1 | Bus cycle present this clock |
| busAddr | input | WORD_W | Bus cycle address |
| busData | input | WORD_W | Bus cycle data |
| busIsFetch | input | 1 | 1 = instruction fetch, 0 = data access |
| busIsWrite | input | 1 | 1 = write, 0 = read |
| busSize | input | 2 | Access size code |
| retire | input | 1 | Instruction retire strobe |
| matchFlagA | output | 1 | Sticky channel A hit flag |
| matchFlagB | output | 1 | Sticky channel B hit flag |
| breakReq | output | 1 | One-cycle break request |

## Verification
The hardest state to reach is the channel B counter sitting at its floor of 1 while after-mode arming, flag clears and a count rewrite all land close together. In that situation the decrement, the reload and the fire decision all compete in the same cycle. The stimulus first walks the counter down through exactly N fetches and then keeps fetching past the floor. It then rewrites the count and repeats the sequence. A mixed phase of pseudo-random cycles then runs with both channels armed, with retire strobes and flag clears interleaved. A behavioural model in the bench predicts both flags and the request on every clock.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int CH_NUM      = 2;
  localparam int REG_SEL_W   = 4;
  localparam int REGS_PER_CH = 3;
  localparam int OFS_ADDR    = 0;
  localparam int OFS_MASK    = 1;
  localparam int OFS_COND    = 2;
  localparam int REG_DATA    = 6;
  localparam int REG_DMASK   = 7;
  localparam int REG_FLAGS   = 8;
  localparam int REG_COUNT   = 9;
  localparam int COND_W      = 10;

  typedef struct packed {
    logic       dataChk;
    logic       countEn;
    logic       afterExec;
    logic [1:0] sizeCode;
    logic       sizeChk;
    logic       onWrite;
    logic       onRead;
    logic       onData;
    logic       onFetch;
  } brkCond_t;

  typedef struct packed {
    logic cntDec;
  } ctlStrobe_t;
endpackage

// File: rtl/brk_datapath.sv
module brk_datapath
  import brk_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [REG_SEL_W-1:0] cfgSel,
  input  logic [WORD_W-1:0]    cfgWrData,
  input  logic                 busValid,
  input  logic [WORD_W-1:0]    busAddr,
  input  logic [WORD_W-1:0]    busData,
  input  logic                 busIsFetch,
  input  logic                 busIsWrite,
  input  logic [1:0]           busSize,
  input  ctlStrobe_t           strb,
  output logic [CH_NUM-1:0]    chHit,
  output logic [CH_NUM-1:0]    chAfter,
  output logic                 cntEnB,
  output logic                 cntLast
);
  localparam int CH_B = CH_NUM - 1;

  logic [WORD_W-1:0] cmpAddr [CH_NUM];
  logic [WORD_W-1:0] cmpMask [CH_NUM];
  brkCond_t          cond    [CH_NUM];
  logic [WORD_W-1:0] cmpData;
  logic [WORD_W-1:0] dataMask;
  logic [CNT_W-1:0]  cntVal;
  logic              cntWrite;

  assign cntWrite = cfgWrEn && (cfgSel == REG_SEL_W'(REG_COUNT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < CH_NUM; c++) begin
        cmpAddr[c] <= '0;
        cmpMask[c] <= '0;
        cond[c]    <= '0;
      end
      cmpData  <= '0;
      dataMask <= '0;
    end else if (cfgWrEn) begin
      for (int c = 0; c < CH_NUM; c++) begin
        if (cfgSel == REG_SEL_W'(c * REGS_PER_CH + OFS_ADDR)) cmpAddr[c] <= cfgWrData;
        if (cfgSel == REG_SEL_W'(c * REGS_PER_CH + OFS_MASK)) cmpMask[c] <= cfgWrData;
        if (cfgSel == REG_SEL_W'(c * REGS_PER_CH + OFS_COND))
          cond[c] <= brkCond_t'(cfgWrData[COND_W-1:0]);
      end
      if (cfgSel == REG_SEL_W'(REG_DATA))  cmpData  <= cfgWrData;
      if (cfgSel == REG_SEL_W'(REG_DMASK)) dataMask <= cfgWrData;
    end
  end

  // Execution counter: reload wins over decrement
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cntVal <= '0;
    else if (cntWrite)      cntVal <= cfgWrData[CNT_W-1:0];
    else if (strb.cntDec)   cntVal <= cntVal - 1'b1;
  end

  assign cntLast = (cntVal <= CNT_W'(1));
  assign cntEnB  = cond[CH_B].countEn;

  for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
    logic addrOk, typeOk, dirOk, sizeOk, dataOk;
    assign addrOk = ((busAddr ^ cmpAddr[c]) & ~cmpMask[c]) == '0;
    assign typeOk = busIsFetch ? cond[c].onFetch : cond[c].onData;
    assign dirOk  = busIsWrite ? cond[c].onWrite : cond[c].onRead;
    assign sizeOk = !cond[c].sizeChk || (busSize == cond[c].sizeCode);
    if (c == CH_B) begin : g_data
      assign dataOk = !cond[c].dataChk || (((busData ^ cmpData) & ~dataMask) == '0);
    end else begin : g_nodata
      assign dataOk = 1'b1;
    end
    assign chHit[c]   = busValid && addrOk && typeOk && dirOk && sizeOk && dataOk;
    assign chAfter[c] = cond[c].afterExec;
  end

  // R6: control must never decrement a counter already at its floor
  a_r6_cnt_floor: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntDec |-> !cntLast);
  // R6: a decrement without a reload lowers the count by one
  a_r6_cnt_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cntDec && !cntWrite) |=> (cntVal == $past(cntVal) - 1'b1));
endmodule

// File: rtl/brk_control.sv
module brk_control
  import brk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CH_NUM-1:0] chHit,
  input  logic [CH_NUM-1:0] chAfter,
  input  logic              cntEnB,
  input  logic              cntLast,
  input  logic              retire,
  input  logic              flagWr,
  input  logic [CH_NUM-1:0] flagWrData,
  output ctlStrobe_t        strb,
  output logic [CH_NUM-1:0] matchFlag,
  output logic              breakReq
);
  localparam int CH_B = CH_NUM - 1;

  logic [CH_NUM-1:0] pend;
  logic [CH_NUM-1:0] chEvent;
  logic [CH_NUM-1:0] fire;
  logic [CH_NUM-1:0] keepMask;

  always_comb begin
    for (int c = 0; c < CH_NUM; c++)
      chEvent[c] = chAfter[c] ? (pend[c] && retire) : chHit[c];
    fire       = chEvent;
    fire[CH_B] = chEvent[CH_B] && (!cntEnB || cntLast);
    strb.cntDec = chEvent[CH_B] && cntEnB && !cntLast;
    keepMask   = flagWr ? flagWrData : '1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend      <= '0;
      matchFlag <= '0;
      breakReq  <= 1'b0;
    end else begin
      pend      <= (pend & ~{CH_NUM{retire}}) | (chHit & chAfter);
      matchFlag <= (matchFlag & keepMask) | fire;
      breakReq  <= |fire;
    end
  end

  // R4: a before-mode hit on channel A breaks on the next clock
  a_r4_before_break: assert property (@(posedge clk) disable iff (!rstN)
    (chHit[0] && !chAfter[0]) |=> (breakReq && matchFlag[0]));
  // R5: a request needs a retire or a before-mode hit in the prior cycle
  a_r5_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(breakReq) |-> ($past(retire) || $past(|(chHit & ~chAfter))));
  // R8: simultaneous before-mode hits set both flags with a request
  a_r8_both: assert property (@(posedge clk) disable iff (!rstN)
    (&(chHit & ~chAfter) && !cntEnB) |=> (breakReq && (&matchFlag)));
  // R9: a flag stays set unless software writes zero to it
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (matchFlag[0] && !(flagWr && !flagWrData[0])) |=> matchFlag[0]);
  // R9: a request is always reflected in at least one flag
  a_r9_flag_with_req: assert property (@(posedge clk) disable iff (!rstN)
    breakReq |-> (|matchFlag));
endmodule

// File: rtl/brk_unit.sv
module brk_unit
  import brk_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [REG_SEL_W-1:0] cfgSel,
  input  logic [WORD_W-1:0]    cfgWrData,
  input  logic                 busValid,
  input  logic [WORD_W-1:0]    busAddr,
  input  logic [WORD_W-1:0]    busData,
  input  logic                 busIsFetch,
  input  logic                 busIsWrite,
  input  logic [1:0]           busSize,
  input  logic                 retire,
  output logic                 matchFlagA,
  output logic                 matchFlagB,
  output logic                 breakReq
);
  ctlStrobe_t        strb;
  logic [CH_NUM-1:0] chHit, chAfter, matchFlag;
  logic              cntEnB, cntLast, flagWr;

  assign flagWr = cfgWrEn && (cfgSel == REG_SEL_W'(REG_FLAGS));

  brk_datapath #(.WORD_W(WORD_W), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .busValid(busValid), .busAddr(busAddr), .busData(busData), .busIsFetch(busIsFetch),
    .busIsWrite(busIsWrite), .busSize(busSize), .strb(strb), .chHit(chHit),
    .chAfter(chAfter), .cntEnB(cntEnB), .cntLast(cntLast)
  );

  brk_control i_ctl (
    .clk(clk), .rstN(rstN), .chHit(chHit), .chAfter(chAfter), .cntEnB(cntEnB),
    .cntLast(cntLast), .retire(retire), .flagWr(flagWr),
    .flagWrData(cfgWrData[CH_NUM-1:0]), .strb(strb), .matchFlag(matchFlag),
    .breakReq(breakReq)
  );

  assign matchFlagA = matchFlag[0];
  assign matchFlagB = matchFlag[1];
endmodule

// File: tb/test_brk_unit.sv
module test_brk_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgSel = '0;
  logic [31:0] cfgWrData = '0;
  logic        busValid = 1'b0;
  logic [31:0] busAddr = '0, busData = '0;
  logic        busIsFetch = 1'b0, busIsWrite = 1'b0;
  logic [1:0]  busSize = '0;
  logic        retire = 1'b0;
  logic        matchFlagA, matchFlagB, breakReq;

  int checks = 0, fails = 0;
  string curReq = "R10";
  bit done = 1'b0;

  // condition bits
  localparam int C_FETCH = 1, C_DATA = 2, C_RD = 4, C_WR = 8, C_SZ = 16;
  localparam int C_AFTER = 128, C_CNT = 256, C_DCHK = 512;

  always #4 clk = ~clk;

  brk_unit i_brk_unit (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .busValid(busValid), .busAddr(busAddr), .busData(busData), .busIsFetch(busIsFetch),
    .busIsWrite(busIsWrite), .busSize(busSize), .retire(retire),
    .matchFlagA(matchFlagA), .matchFlagB(matchFlagB), .breakReq(breakReq)
  );

  // behavioural reference
  logic [31:0] mAddr [2], mMask [2], mCond [2];
  logic [31:0] mData, mDmask;
  int          mCnt;
  bit          mPend [2];
  bit          eFlag [2];
  bit          eReq;

  function automatic bit modelHit(int ch);
    bit ok;
    ok = busValid;
    if (((busAddr ^ mAddr[ch]) & ~mMask[ch]) != 0) ok = 0;
    if (busIsFetch ? !mCond[ch][0] : !mCond[ch][1]) ok = 0;
    if (busIsWrite ? !mCond[ch][3] : !mCond[ch][2]) ok = 0;
    if (mCond[ch][4] && busSize != mCond[ch][6:5]) ok = 0;
    if (ch == 1 && mCond[1][9] && (((busData ^ mData) & ~mDmask) != 0)) ok = 0;
    return ok;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < 2; c++) begin
        mAddr[c] = 0; mMask[c] = 0; mCond[c] = 0; mPend[c] = 0; eFlag[c] = 0;
      end
      mData = 0; mDmask = 0; mCnt = 0; eReq = 0;
    end else begin
      bit hit [2];
      bit ev [2];
      bit fireA, fireB, dec;
      for (int c = 0; c < 2; c++) begin
        hit[c] = modelHit(c);
        ev[c] = mCond[c][7] ? (mPend[c] && retire) : hit[c];
      end
      fireA = ev[0];
      fireB = ev[1] && (!mCond[1][8] || mCnt <= 1);
      dec   = ev[1] && mCond[1][8] && mCnt > 1;
      for (int c = 0; c < 2; c++)
        mPend[c] = (mPend[c] && !retire) || (hit[c] && mCond[c][7]);
      if (cfgWrEn && cfgSel == 8) begin
        eFlag[0] = eFlag[0] && cfgWrData[0];
        eFlag[1] = eFlag[1] && cfgWrData[1];
      end
      eFlag[0] = eFlag[0] || fireA;
      eFlag[1] = eFlag[1] || fireB;
      eReq = fireA || fireB;
      if (cfgWrEn && cfgSel == 9) mCnt = int'(cfgWrData[11:0]);
      else if (dec) mCnt = mCnt - 1;
      if (cfgWrEn) begin
        case (cfgSel)
          0: mAddr[0] = cfgWrData;
          1: mMask[0] = cfgWrData;
          2: mCond[0] = cfgWrData & 32'h3FF;
          3: mAddr[1] = cfgWrData;
          4: mMask[1] = cfgWrData;
          5: mCond[1] = cfgWrData & 32'h3FF;
          6: mData = cfgWrData;
          7: mDmask = cfgWrData;
          default: ;
        endcase
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (matchFlagA !== eFlag[0] || matchFlagB !== eFlag[1] || breakReq !== eReq) begin
        fails++;
        $display("FAIL %s: flags/req actual %b%b/%b expected %b%b/%b", curReq,
                 matchFlagA, matchFlagB, breakReq, eFlag[0], eFlag[1], eReq);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int sel, logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1; cfgSel = 4'(sel); cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  task automatic bus(logic [31:0] a, logic [31:0] d, bit f, bit w, int sz);
    @(negedge clk);
    busValid = 1; busAddr = a; busData = d; busIsFetch = f; busIsWrite = w; busSize = 2'(sz);
    @(negedge clk);
    busValid = 0;
    @(negedge clk);
  endtask

  task automatic ret();
    @(negedge clk);
    retire = 1;
    @(negedge clk);
    retire = 0;
    @(negedge clk);
  endtask

  task automatic expectReq(bit e, string tag);
    checks++;
    if (breakReq !== e) begin
      fails++;
      $display("FAIL %s: breakReq actual %b expected %b", tag, breakReq, e);
    end
  endtask

  initial begin
    idle(3);
    // R10: reset state
    checks++;
    if (matchFlagA !== 0 || matchFlagB !== 0 || breakReq !== 0) begin
      fails++;
      $display("FAIL R10: outputs actual %b%b%b expected 000", matchFlagA, matchFlagB, breakReq);
    end
    rstN = 1;
    curReq = "R10";
    bus(32'h0, 0, 1, 0, 2);

    curReq = "R1";
    wr(0, 32'h8404); wr(1, 32'hFFF); wr(2, C_FETCH | C_RD);
    bus(32'h8000, 0, 1, 0, 2); wr(8, 0);
    bus(32'h8FFE, 0, 1, 0, 2); wr(8, 0);
    bus(32'h9000, 0, 1, 0, 2); bus(32'h7FFE, 0, 1, 0, 2);
    wr(2, 0);
    wr(3, 32'h8010); wr(4, 32'h6); wr(5, C_FETCH | C_RD);
    for (int a = 32'h800E; a <= 32'h8018; a++) begin
      bus(32'(a), 0, 1, 0, 1); wr(8, 0);
    end
    wr(5, 0);

    curReq = "R2";
    wr(0, 32'h100); wr(1, 0); wr(2, C_DATA | C_WR);
    bus(32'h100, 0, 0, 1, 2); wr(8, 0);
    bus(32'h100, 0, 0, 0, 2); bus(32'h100, 0, 1, 1, 2); bus(32'h100, 0, 1, 0, 2);

    curReq = "R3";
    wr(2, C_DATA | C_RD | C_SZ | (2 << 5));
    bus(32'h100, 0, 0, 0, 2); wr(8, 0);
    bus(32'h100, 0, 0, 0, 1); bus(32'h100, 0, 0, 0, 0);
    wr(2, C_DATA | C_RD);
    for (int s = 0; s < 3; s++) begin bus(32'h100, 0, 0, 0, s); wr(8, 0); end

    curReq = "R4";
    wr(0, 32'h200); wr(2, C_FETCH | C_RD);
    @(negedge clk);
    busValid = 1; busAddr = 32'h200; busIsFetch = 1; busIsWrite = 0;
    @(negedge clk);
    busValid = 0;
    expectReq(1, "R4");
    @(negedge clk);
    expectReq(0, "R4");
    wr(8, 0);

    curReq = "R5";
    wr(2, C_FETCH | C_RD | C_AFTER);
    bus(32'h200, 0, 1, 0, 2);
    idle(3);
    expectReq(0, "R5");
    ret();
    wr(8, 0);
    wr(2, 0);

    curReq = "R6";
    wr(3, 32'h1000); wr(4, 0); wr(5, C_FETCH | C_RD | C_CNT); wr(9, 5);
    for (int k = 0; k < 7; k++) bus(32'h1000, 0, 1, 0, 2);
    wr(8, 0); wr(9, 2);
    for (int k = 0; k < 3; k++) bus(32'h1000, 0, 1, 0, 2);
    wr(8, 0);
    wr(5, C_FETCH | C_RD | C_CNT | C_AFTER); wr(9, 2);
    for (int k = 0; k < 3; k++) begin bus(32'h1000, 0, 1, 0, 2); ret(); end
    wr(8, 0);

    curReq = "R7";
    wr(3, 32'h300); wr(5, C_DATA | C_RD | C_DCHK); wr(6, 0); wr(7, 0);
    bus(32'h300, 0, 0, 0, 2); wr(8, 0);
    bus(32'h300, 1, 0, 0, 2);
    wr(6, 32'h5); wr(7, 32'hF);
    bus(32'h300, 32'hA, 0, 0, 2); wr(8, 0);
    bus(32'h300, 32'h1A, 0, 0, 2);

    curReq = "R8";
    wr(0, 32'h400); wr(2, C_FETCH | C_RD); wr(3, 32'h400); wr(5, C_FETCH | C_RD);
    bus(32'h400, 0, 1, 0, 2);

    curReq = "R9";
    wr(8, 32'h2);
    idle(2);
    @(negedge clk);
    cfgWrEn = 1; cfgSel = 8; cfgWrData = 0;
    busValid = 1; busAddr = 32'h400; busIsFetch = 1; busIsWrite = 0;
    @(negedge clk);
    cfgWrEn = 0; busValid = 0;
    idle(2);

    curReq = "R8";
    wr(1, 32'hF0); wr(2, C_FETCH | C_DATA | C_RD | C_WR | C_AFTER);
    wr(4, 32'h0F); wr(5, C_FETCH | C_RD | C_CNT); wr(9, 3);
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      busValid = 1'($urandom_range(0, 1));
      busAddr = 32'h400 | 32'($urandom_range(0, 255));
      busIsFetch = 1'($urandom_range(0, 1));
      busIsWrite = 1'($urandom_range(0, 1));
      busSize = 2'($urandom_range(0, 2));
      retire = ($urandom_range(0, 3) == 0);
      cfgWrEn = ($urandom_range(0, 15) == 0);
      cfgSel = cfgWrEn && $urandom_range(0, 1) ? 4'd9 : 4'd8;
      cfgWrData = 32'($urandom_range(0, 4));
    end
    @(negedge clk);
    busValid = 0; retire = 0; cfgWrEn = 0;
    idle(4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule